// File: doc/BRIEF.md
# Serial Byte Transmitter with Flag Handshake

This block sends bytes on an asynchronous serial line. A host writes a byte into a holding register and then writes zero to the empty flag. That write is the handover. The byte moves into the shift register at the next frame boundary, and the empty flag returns to 1 at that moment. A separate end flag tells the host when the line has drained, so it knows when it may turn the transmitter off.

A direct-memory-access engine can also write the holding register, prompted by the empty interrupt. Such a write hands the byte over on its own only when the engine's select bit is 0 and its transfer count is not zero. In every other case the host clears the flag itself.

Turning the transmitter on first sends one frame of all ones. While the transmitter is off, a port data bit and a port direction bit own the pin. A host produces a break by driving the port low as an output and then disabling the transmitter.

Top module: `sertx_top`

Register select (`wr_addr`):
- 0 is the holding register.
- 1 is control: bit 0 enables the transmitter, bit 1 enables the interrupt.
- 2 is status: writing bit 0 as 0 clears the empty flag.
- 3 is port: bit 0 is the port level, bit 1 is the direction, with 1 meaning output.

## Requirements
- R1: After reset, `txd` is 1, `empty_flag` is 1, `end_flag` is 1 and `txe_irq` is 0.
- R2: The control write that turns the enable bit from 0 to 1 starts a frame of ten bits that are all 1. No queued byte begins before that frame has completed.
- R3: A data frame is one start bit of 0, then the 8 data bits least significant first, then one stop bit of 1. Each bit holds for 16 asserted `baud_tick` cycles.
- R4: A write to register 0 alone starts nothing. Writing 0 to status bit 0 while `empty_flag` is 1 clears the flag. The byte then loads at the next frame boundary, and `empty_flag` returns to 1 in the cycle of that load.
- R5: `end_flag` drops when the flag is cleared or a byte loads. It rises at the end of a frame if `empty_flag` is 1 and no clear happens in that cycle. `end_flag` is never 1 while `empty_flag` is 0.
- R6: `txe_irq` is 1 exactly when `empty_flag` is 1 and control bit 1 is set.
- R7: A control write with bit 0 equal to 0 forces `empty_flag` and `end_flag` to 1 and stops the frame in progress, starting with the next cycle.
- R8: While disabled, `txd` follows port bit 0 when port bit 1 is 1. Otherwise `txd` is 1. This is how a break is produced.
- R9: While enabled, `txd` carries the serial output whatever the port bits hold.
- R10: A `dma_wr` pulse loads `dma_data` into the holding register. It clears `empty_flag` only when `dma_isel` is 0 and `dma_cnt` is not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 2 | Host register select |
| wr_data | input | DW | Host write data |
| dma_wr | input | 1 | DMA write strobe to holding register |
| dma_data | input | DW | DMA write data |
| dma_isel | input | 1 | DMA interrupt-select mode bit |
| dma_cnt | input | CW | DMA remaining transfer count |
| txd | output | 1 | Serial line |
| txe_irq | output | 1 | Transmit-empty interrupt request |
| empty_flag | output | 1 | Holding register empty |
| end_flag | output | 1 | Transmission ended |

## Verification
The bench queues a byte while the enable frame is still running. A design that skipped that frame, or cut it short, would show a start bit early.

It writes data without clearing the flag and watches for silence. A design that started on the data write alone would send a frame here.

It issues DMA writes under each select and count combination. A design that ignored either condition would clear `empty_flag` when it must stay set.

It disables the transmitter in mid-frame and then drives a break through the port. A design that kept shifting would leave the flags low, and one that ignored the port direction would leave `txd` high or float the wrong level.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   typedef enum logic [1:0] {
      SEL_HOLD = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_STAT = 2'd2,
      SEL_PORT = 2'd3
   } sertx_sel_e;

   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_IE_BIT  = 1;
   localparam int STAT_CLR_BIT = 0;
   localparam int PORT_LVL_BIT = 0;
   localparam int PORT_DIR_BIT = 1;
endpackage

// File: rtl/sertx_regs.sv
module sertx_regs
   import sertx_pkg::*;
#(
   parameter int DW       = 8,
   parameter int CW       = 8,
   parameter bit DMA_AUTO = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          dma_wr,
   input  logic [DW-1:0] dma_data,
   input  logic          dma_isel,
   input  logic [CW-1:0] dma_cnt,
   input  logic          load,
   input  logic          frame_done,
   output logic          te_q,
   output logic          ie_q,
   output logic          port_lvl,
   output logic          port_dir,
   output logic [DW-1:0] hold_q,
   output logic          empty_q,
   output logic          end_q,
   output logic          te_rise,
   output logic          te_drop
);
   logic ctrl_wr, sw_clr, auto_clr, any_clr, te_next;

   assign ctrl_wr  = wr_en && (sertx_sel_e'(wr_addr) == SEL_CTRL);
   assign te_rise  = ctrl_wr && wr_data[CTRL_EN_BIT] && !te_q;
   assign te_drop  = ctrl_wr && !wr_data[CTRL_EN_BIT];
   assign te_next  = ctrl_wr ? wr_data[CTRL_EN_BIT] : te_q;
   assign sw_clr   = wr_en && (sertx_sel_e'(wr_addr) == SEL_STAT)
                     && !wr_data[STAT_CLR_BIT] && empty_q;

   generate
      if (DMA_AUTO) begin : g_auto
         assign auto_clr = dma_wr && !dma_isel && (dma_cnt != '0);
      end else begin : g_noauto
         assign auto_clr = 1'b0;
      end
   endgenerate

   assign any_clr = sw_clr || auto_clr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         te_q     <= 1'b0;
         ie_q     <= 1'b0;
         port_lvl <= 1'b1;
         port_dir <= 1'b0;
         hold_q   <= '0;
         empty_q  <= 1'b1;
         end_q    <= 1'b1;
      end else begin
         te_q <= te_next;
         if (ctrl_wr) ie_q <= wr_data[CTRL_IE_BIT];
         if (wr_en && (sertx_sel_e'(wr_addr) == SEL_PORT)) begin
            port_lvl <= wr_data[PORT_LVL_BIT];
            port_dir <= wr_data[PORT_DIR_BIT];
         end
         if (dma_wr) hold_q <= dma_data;
         else if (wr_en && (sertx_sel_e'(wr_addr) == SEL_HOLD)) hold_q <= wr_data;

         if (!te_next) begin
            empty_q <= 1'b1;
            end_q   <= 1'b1;
         end else if (load) begin
            empty_q <= 1'b1;
            end_q   <= 1'b0;
         end else if (any_clr) begin
            empty_q <= 1'b0;
            end_q   <= 1'b0;
         end else if (frame_done) begin
            end_q   <= empty_q;
         end
      end
   end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
   parameter int DW  = 8,
   parameter int OVS = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          abort,
   input  logic          start_idle,
   input  logic          load,
   input  logic [DW-1:0] data,
   input  logic          tick,
   output logic          ser,
   output logic          busy,
   output logic          done
);
   localparam int FRAME = DW + 2;
   localparam int TW    = $clog2(OVS);
   localparam int BW    = $clog2(FRAME);
   localparam logic [TW-1:0] TICK_LAST = TW'(OVS - 1);
   localparam logic [BW-1:0] BIT_LAST  = BW'(FRAME - 1);

   logic [FRAME-1:0] sh;
   logic [TW-1:0]    tick_cnt;
   logic [BW-1:0]    bit_cnt;
   logic             bit_end;

   assign bit_end = busy && tick && (tick_cnt == TICK_LAST);
   assign done    = bit_end && (bit_cnt == BIT_LAST);
   assign ser     = busy ? sh[0] : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n || abort) begin
         busy     <= 1'b0;
         sh       <= '1;
         tick_cnt <= '0;
         bit_cnt  <= '0;
      end else if (start_idle || load) begin
         busy     <= 1'b1;
         sh       <= start_idle ? '1 : {1'b1, data, 1'b0};
         tick_cnt <= '0;
         bit_cnt  <= '0;
      end else if (busy && tick) begin
         if (bit_end) begin
            tick_cnt <= '0;
            sh       <= {1'b1, sh[FRAME-1:1]};
            if (bit_cnt == BIT_LAST) begin
               busy    <= 1'b0;
               bit_cnt <= '0;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end else begin
            tick_cnt <= tick_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sertx_pinmux.sv
module sertx_pinmux (
   input  logic te,
   input  logic ser,
   input  logic port_lvl,
   input  logic port_dir,
   output logic pin
);
   always_comb begin
      if (te)            pin = ser;
      else if (port_dir) pin = port_lvl;
      else               pin = 1'b1;
   end
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
   parameter int DW       = 8,
   parameter int CW       = 8,
   parameter int OVS      = 16,
   parameter bit DMA_AUTO = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          baud_tick,
   input  logic          wr_en,
   input  logic [1:0]    wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          dma_wr,
   input  logic [DW-1:0] dma_data,
   input  logic          dma_isel,
   input  logic [CW-1:0] dma_cnt,
   output logic          txd,
   output logic          txe_irq,
   output logic          empty_flag,
   output logic          end_flag
);
   generate
      if (DW < 5)  begin : g_bad_dw  $error("sertx_top: DW must be at least 5"); end
      if (OVS < 2) begin : g_bad_ovs $error("sertx_top: OVS must be at least 2"); end
      if (CW < 1)  begin : g_bad_cw  $error("sertx_top: CW must be at least 1"); end
   endgenerate

   logic          te_q, ie_q, port_lvl, port_dir, empty_q, end_q;
   logic          te_rise, te_drop, load, ser, busy, done;
   logic [DW-1:0] hold_q;

   assign load = te_q && !busy && !empty_q;

   sertx_regs #(.DW(DW), .CW(CW), .DMA_AUTO(DMA_AUTO)) u_regs (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
      .dma_wr, .dma_data, .dma_isel, .dma_cnt,
      .load, .frame_done(done),
      .te_q, .ie_q, .port_lvl, .port_dir, .hold_q,
      .empty_q, .end_q, .te_rise, .te_drop
   );

   sertx_shift #(.DW(DW), .OVS(OVS)) u_shift (
      .clk, .rst_n, .abort(te_drop), .start_idle(te_rise), .load,
      .data(hold_q), .tick(baud_tick), .ser, .busy, .done
   );

   sertx_pinmux u_mux (
      .te(te_q), .ser, .port_lvl, .port_dir, .pin(txd)
   );

   assign txe_irq    = empty_q && ie_q;
   assign empty_flag = empty_q;
   assign end_flag   = end_q;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [1:0] wr_addr,
   input logic       wr_data0,
   input logic       dma_wr,
   input logic       dma_isel,
   input logic       txd,
   input logic       txe_irq,
   input logic       empty_flag,
   input logic       end_flag
);
   a_r5_end_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
      end_flag |-> empty_flag);

   a_r6_irq_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
      txe_irq |-> empty_flag);

   a_r7_disable_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd1 && !wr_data0) |=> (empty_flag && end_flag));

   a_r10_no_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_wr && dma_isel && empty_flag && !(wr_en && wr_addr == 2'd2)) |=> empty_flag);

   a_r3_load_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(empty_flag) && !$past(wr_en && wr_addr == 2'd1)) |-> !txd);
endmodule

bind sertx_top sertx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data0(wr_data[0]), .dma_wr(dma_wr), .dma_isel(dma_isel),
   .txd(txd), .txe_irq(txe_irq), .empty_flag(empty_flag), .end_flag(end_flag)
);

// File: tb/test_sertx_top.sv
`timescale 1ns/1ps
module test_sertx_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       dma_wr = 1'b0;
   logic [7:0] dma_data = 8'd0;
   logic       dma_isel = 1'b0;
   logic [7:0] dma_cnt = 8'd0;
   logic       txd, txe_irq, empty_flag, end_flag;

   int checks = 0;
   int failures = 0;
   bit sparse = 1'b0;
   bit done_flag = 1'b0;
   int tcount = 0;

   always #5 clk = ~clk;

   sertx_top i_sertx_top (
      .clk, .rst_n, .baud_tick, .wr_en, .wr_addr, .wr_data,
      .dma_wr, .dma_data, .dma_isel, .dma_cnt,
      .txd, .txe_irq, .empty_flag, .end_flag
   );

   always @(negedge clk) begin
      tcount++;
      baud_tick = sparse ? (tcount % 3 == 0) : 1'b1;
   end

   // behavioural reference model
   bit   mq[$];
   int   mtick;
   logic m_te, m_ie, m_pl, m_pd, m_empty, m_end;
   logic [7:0] m_hold;
   logic m_busy0, m_done, m_ld, m_clr, m_te_n, m_ctrlw;

   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete(); mtick = 0;
         m_te = 0; m_ie = 0; m_pl = 1; m_pd = 0; m_empty = 1; m_end = 1; m_hold = 0;
      end else begin
         m_busy0 = (mq.size() != 0);
         m_ctrlw = wr_en && wr_addr == 2'd1;
         m_clr   = (wr_en && wr_addr == 2'd2 && !wr_data[0] && m_empty)
                   || (dma_wr && !dma_isel && dma_cnt != 0);
         m_done  = 0;
         if (m_busy0 && baud_tick) begin
            mtick++;
            if (mtick == 16) begin
               mtick = 0;
               void'(mq.pop_front());
               if (mq.size() == 0) m_done = 1;
            end
         end
         m_ld = m_te && !m_busy0 && !m_empty;
         if (m_ld) begin
            mq.delete(); mtick = 0; mq.push_back(1'b0);
            for (int i = 0; i < 8; i++) mq.push_back(m_hold[i]);
            mq.push_back(1'b1);
         end
         if (m_ctrlw && wr_data[0] && !m_te) begin
            mq.delete(); mtick = 0;
            for (int i = 0; i < 10; i++) mq.push_back(1'b1);
         end
         m_te_n = m_ctrlw ? wr_data[0] : m_te;
         if (m_ctrlw && !wr_data[0]) begin mq.delete(); mtick = 0; end
         if (!m_te_n) begin m_empty = 1; m_end = 1; end
         else if (m_ld) begin m_empty = 1; m_end = 0; end
         else if (m_clr) begin m_empty = 0; m_end = 0; end
         else if (m_done) m_end = m_empty;
         if (dma_wr) m_hold = dma_data;
         else if (wr_en && wr_addr == 2'd0) m_hold = wr_data;
         if (m_ctrlw) m_ie = wr_data[1];
         if (wr_en && wr_addr == 2'd3) begin m_pl = wr_data[0]; m_pd = wr_data[1]; end
         m_te = m_te_n;
      end
   end

   function automatic logic m_txd();
      if (m_te) return (mq.size() != 0) ? mq[0] : 1'b1;
      return m_pd ? m_pl : 1'b1;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(posedge clk) begin
      #2;
      if (rst_n && !done_flag) begin
         chk(txd == m_txd(), "R3 txd vs model", txd, m_txd());
         chk(empty_flag == m_empty, "R4 empty vs model", empty_flag, m_empty);
         chk(end_flag == m_end, "R5 end vs model", end_flag, m_end);
         chk(txe_irq == (m_empty & m_ie), "R6 irq vs model", txe_irq, m_empty & m_ie);
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic dma(input logic isel, input logic [7:0] cnt, input logic [7:0] d);
      @(negedge clk); dma_wr = 1; dma_isel = isel; dma_cnt = cnt; dma_data = d;
      @(negedge clk); dma_wr = 0;
   endtask

   task automatic cyc(input int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic capture(output logic [7:0] b, output logic st, output logic sp);
      int lim = 0;
      while (txd && lim < 2000) begin cyc(1); lim++; end
      cyc(8); st = txd;
      for (int i = 0; i < 8; i++) begin cyc(16); b[i] = txd; end
      cyc(16); sp = txd;
   endtask

   task automatic wait_end(input int lim);
      int n = 0;
      while (!end_flag && n < lim) begin cyc(1); n++; end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] b;
      logic st, sp;
      int cnt;
      cyc(3);
      @(negedge clk); rst_n = 1;
      cyc(1);
      chk(txd == 1, "R1 txd", txd, 1);
      chk(empty_flag == 1, "R1 empty", empty_flag, 1);
      chk(end_flag == 1, "R1 end", end_flag, 1);
      chk(txe_irq == 0, "R1 irq", txe_irq, 0);

      wr(2'd3, 8'h02);
      chk(txd == 0, "R8 break while disabled", txd, 0);
      wr(2'd1, 8'h03);
      chk(txd == 1, "R9 enable overrides port", txd, 1);
      chk(txe_irq == 1, "R6 irq when empty and enabled", txe_irq, 1);
      wr(2'd0, 8'h5A);
      wr(2'd2, 8'h00);
      chk(empty_flag == 0, "R4 clear takes flag low", empty_flag, 0);
      chk(txe_irq == 0, "R6 irq low when not empty", txe_irq, 0);
      cnt = 0;
      while (txd && cnt < 1000) begin cyc(1); cnt++; end
      chk(cnt >= 150 && cnt <= 165, "R2 idle frame length", cnt, 158);
      capture(b, st, sp);
      chk(st == 0, "R3 start bit", st, 0);
      chk(b == 8'h5A, "R3 data byte", b, 8'h5A);
      chk(sp == 1, "R3 stop bit", sp, 1);
      wait_end(100);
      chk(end_flag == 1, "R5 end after drain", end_flag, 1);

      wr(2'd0, 8'h3C);
      cnt = 0;
      for (int i = 0; i < 200; i++) begin cyc(1); if (!txd) cnt++; end
      chk(cnt == 0, "R4 data write alone sends nothing", cnt, 0);
      chk(empty_flag == 1, "R4 empty stays set", empty_flag, 1);
      wr(2'd2, 8'h01);
      chk(empty_flag == 1, "R4 writing 1 does not clear", empty_flag, 1);
      wr(2'd2, 8'h00);
      capture(b, st, sp);
      chk(b == 8'h3C, "R3 second byte", b, 8'h3C);
      wait_end(100);

      dma(1'b1, 8'd5, 8'h11);
      chk(empty_flag == 1, "R10 select mode 1 no auto clear", empty_flag, 1);
      dma(1'b0, 8'd0, 8'h22);
      chk(empty_flag == 1, "R10 zero count no auto clear", empty_flag, 1);
      dma(1'b0, 8'd4, 8'h77);
      chk(end_flag == 0, "R5 end low while frame pending", end_flag, 0);
      capture(b, st, sp);
      chk(b == 8'h77, "R10 dma byte sent", b, 8'h77);
      wait_end(100);

      sparse = 1;
      wr(2'd0, 8'hC3);
      wr(2'd2, 8'h00);
      cyc(5);
      wait_end(2000);
      chk(end_flag == 1, "R3 sparse tick frame drains", end_flag, 1);
      sparse = 0;

      wr(2'd3, 8'h00);
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h00);
      cyc(40);
      chk(txd == 0, "R3 mid frame low", txd, 0);
      wr(2'd1, 8'h00);
      chk(txd == 1, "R7 line idle after disable", txd, 1);
      chk(empty_flag == 1 && end_flag == 1, "R7 flags forced", {empty_flag, end_flag}, 3);
      wr(2'd3, 8'h02);
      chk(txd == 0, "R8 break driven low", txd, 0);
      wr(2'd3, 8'h01);
      chk(txd == 1, "R8 input direction idles high", txd, 1);
      cyc(4);
      finish_run();
   end
endmodule